// File: doc/BRIEF.md
# Crystal Rate Trimming Second Prescaler

The block divides an oscillator-rate enable, nominally 32,768 pulses per second, down to a one-second tick. It trims the rate digitally, with no analog trimming: over a repeating 64-minute correction cycle it makes some seconds shorter or longer by a fixed number of oscillator pulses. A 6-bit calibration word selects the correction. Bits [4:0] hold a magnitude N from 0 to 31. Bit 5 is the sign: 1 speeds the clock up and 0 slows it down. The minutes that are corrected are minutes 0 through 2·N−1 of the cycle, so at most 62 minutes. In each of those minutes only the first second (second 0) is altered. A positive setting makes that second SHORT_BY pulses shorter (256 by default). A negative setting makes it LONG_BY pulses longer (128 by default).

A three-state machine holds the kind of second now in progress. SEC_PLAIN lasts BASE_CYCLES pulses, SEC_SHORT lasts BASE_CYCLES−SHORT_BY pulses and SEC_LONG lasts BASE_CYCLES+LONG_BY pulses. The machine has a single transition rule. While reset is held, and again at every tick, it enters the state chosen for the next second from three things: the next second index, the next minute index, and the calibration in force for that second. Any state can move to any state, and a self-loop is allowed. The calibration word is registered only while reset is held and at the tick that closes minute 63. A new value therefore always takes effect at the start of a cycle. The second index and the minute index within the cycle are brought out so that the block can be observed in test.

Top module: `rate_trim_prescaler`

## Requirements
- R1: A second that is not corrected lasts exactly BASE_CYCLES enabled clock cycles. sec_tick is high on the last of those cycles.
- R2: sec_tick is a single-cycle pulse that is only ever high in a cycle where osc_en is high.
- R3: sec_pos steps from 0 to SECS−1 and min_pos from 0 to MINS−1, both wrapping to 0. Each advances only on a tick.
- R4: When cal bit 5 = 1 and the magnitude N = cal[4:0] is nonzero, second 0 of each minute m with m < 2·N lasts BASE_CYCLES−SHORT_BY enabled cycles.
- R5: When cal bit 5 = 0 and N > 0, second 0 of each minute m with m < 2·N lasts BASE_CYCLES+LONG_BY enabled cycles.
- R6: With N = 0, every second lasts BASE_CYCLES enabled cycles, whatever the value of bit 5.
- R7: Seconds 1 to SECS−1, and second 0 of any minute m ≥ 2·N, are never corrected.
- R8: cal_in is taken only at the tick that ends second SECS−1 of minute MINS−1. Changes made at any other time have no effect on the current cycle.
- R9: While rst_n is low (synchronous, active low), sec_pos and min_pos are 0 and no tick is issued. The cal_in value held during reset governs the first cycle.
- R10: Cycles with osc_en low do not advance the count, the tick or the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One pulse per oscillator period |
| cal_in | input | 6 | Calibration: [4:0] magnitude, [5] sign (1 = faster) |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| sec_pos | output | $clog2(SECS) | Second index within the minute |
| min_pos | output | $clog2(MINS) | Minute index within the correction cycle |

## Verification
The bench goes after the edges of the corrected span. It checks minute 2·N−1, which must be corrected, and minute 2·N, which must not. A design with an off-by-one compare would trim one minute too many or too few. The magnitude-0 case is run with both signs, so a design that let the sign act on its own would alter seconds when no correction is asked for. Magnitudes of 31 with both signs show that minutes 62 and 63 are never touched. The bench also changes cal_in in the middle of a cycle, which catches a design that samples the word continuously and mixes two settings within one cycle. Random gaps in osc_en catch a design that counts clock cycles instead of oscillator pulses.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
    typedef enum logic [1:0] {
        SEC_PLAIN = 2'd0,
        SEC_SHORT = 2'd1,
        SEC_LONG  = 2'd2
    } sec_kind_t;
endpackage

// File: rtl/rtp_position.sv
module rtp_position #(
    parameter int SECS  = 60,
    parameter int MINS  = 64,
    parameter int SEC_W = 6,
    parameter int MIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [SEC_W-1:0] sec_q,
    output logic [MIN_W-1:0] min_q,
    output logic [SEC_W-1:0] nxt_sec,
    output logic [MIN_W-1:0] nxt_min,
    output logic             wrap
);
    logic last_sec;
    logic last_min;

    always_comb begin
        last_sec = (sec_q == SEC_W'(SECS - 1));
        last_min = (min_q == MIN_W'(MINS - 1));
        nxt_sec  = last_sec ? '0 : sec_q + 1'b1;
        nxt_min  = min_q;
        if (last_sec) begin
            nxt_min = last_min ? '0 : min_q + 1'b1;
        end
        wrap = tick && last_sec && last_min;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (tick) begin
            sec_q <= nxt_sec;
            min_q <= nxt_min;
        end
    end
endmodule

// File: rtl/rtp_cal_hold.sv
module rtp_cal_hold #(
    parameter int MAG_W = 5,
    parameter int MIN_W = 6
) (
    input  logic                   clk,
    input  logic                   load,
    input  logic [MAG_W:0]         cal_in,
    input  logic                   first_sec,
    input  logic [MIN_W-1:0]       min_idx,
    output logic [MAG_W:0]         cal_q,
    output rtp_pkg::sec_kind_t     kind_next
);
    import rtp_pkg::*;

    logic [MAG_W:0]   cal_use;
    logic [MAG_W-1:0] mag;
    logic             in_span;

    always_ff @(posedge clk) begin
        if (load) begin
            cal_q <= cal_in;
        end
    end

    always_comb begin
        cal_use = load ? cal_in : cal_q;
        mag     = cal_use[MAG_W-1:0];
        in_span = first_sec && (int'(min_idx) < 2 * int'(mag));
        if (!in_span) begin
            kind_next = SEC_PLAIN;
        end else if (cal_use[MAG_W]) begin
            kind_next = SEC_SHORT;
        end else begin
            kind_next = SEC_LONG;
        end
    end
endmodule

// File: rtl/rtp_sec_fsm.sv
module rtp_sec_fsm #(
    parameter int BASE_CYCLES = 32768,
    parameter int SHORT_BY    = 256,
    parameter int LONG_BY     = 128,
    parameter int CNT_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_en,
    input  rtp_pkg::sec_kind_t kind_next,
    output logic               tick
);
    import rtp_pkg::*;

    localparam logic [CNT_W-1:0] LAST_PLAIN = CNT_W'(BASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(BASE_CYCLES - SHORT_BY - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(BASE_CYCLES + LONG_BY - 1);

    sec_kind_t        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    // state register: reload at reset and at every second boundary
    always_ff @(posedge clk) begin
        if (!rst_n || tick) begin
            state <= kind_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (osc_en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            SEC_PLAIN: last_cnt = LAST_PLAIN;
            SEC_SHORT: last_cnt = LAST_SHORT;
            SEC_LONG:  last_cnt = LAST_LONG;
            default:   last_cnt = LAST_PLAIN;
        endcase
        tick = rst_n && osc_en && (cnt == last_cnt);
    end
endmodule

// File: rtl/rate_trim_prescaler.sv
module rate_trim_prescaler #(
    parameter int BASE_CYCLES = 32768,
    parameter int SHORT_BY    = 256,
    parameter int LONG_BY     = 128,
    parameter int SECS        = 60,
    parameter int MINS        = 64,
    parameter int MAG_W       = 5,
    localparam int SEC_W      = $clog2(SECS),
    localparam int MIN_W      = $clog2(MINS),
    localparam int CNT_W      = $clog2(BASE_CYCLES + LONG_BY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic [MAG_W:0]   cal_in,
    output logic             sec_tick,
    output logic [SEC_W-1:0] sec_pos,
    output logic [MIN_W-1:0] min_pos
);
    import rtp_pkg::*;

    logic [SEC_W-1:0] nxt_sec;
    logic [MIN_W-1:0] nxt_min;
    logic             cyc_wrap;
    logic             cal_load;
    logic             first_sec;
    logic [MIN_W-1:0] min_idx;
    logic [MAG_W:0]   cal_q;
    sec_kind_t        kind_next;

    assign cal_load  = !rst_n || cyc_wrap;
    assign first_sec = !rst_n || (nxt_sec == '0);
    assign min_idx   = rst_n ? nxt_min : '0;

    rtp_position #(
        .SECS(SECS), .MINS(MINS), .SEC_W(SEC_W), .MIN_W(MIN_W)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick),
        .sec_q(sec_pos), .min_q(min_pos),
        .nxt_sec(nxt_sec), .nxt_min(nxt_min), .wrap(cyc_wrap)
    );

    rtp_cal_hold #(
        .MAG_W(MAG_W), .MIN_W(MIN_W)
    ) u_cal (
        .clk(clk), .load(cal_load), .cal_in(cal_in),
        .first_sec(first_sec), .min_idx(min_idx),
        .cal_q(cal_q), .kind_next(kind_next)
    );

    rtp_sec_fsm #(
        .BASE_CYCLES(BASE_CYCLES), .SHORT_BY(SHORT_BY),
        .LONG_BY(LONG_BY), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
        .kind_next(kind_next), .tick(sec_tick)
    );
endmodule

// File: rtl/rtp_checker.sv
module rtp_checker #(
    parameter int BASE_CYCLES = 32768,
    parameter int SHORT_BY    = 256,
    parameter int LONG_BY     = 128,
    parameter int SECS        = 60,
    parameter int MINS        = 64,
    parameter int MAG_W       = 5,
    parameter int SEC_W       = 6,
    parameter int MIN_W       = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en,
    input logic             sec_tick,
    input logic [SEC_W-1:0] sec_pos,
    input logic [MIN_W-1:0] min_pos,
    input logic [MAG_W:0]   cal_q
);
    int unsigned en_cnt;
    logic        at_wrap;
    logic        in_span;

    always_ff @(posedge clk) begin
        if (!rst_n || sec_tick) en_cnt <= 0;
        else if (osc_en)        en_cnt <= en_cnt + 1;
    end

    always_comb begin
        at_wrap = sec_tick && (int'(sec_pos) == SECS - 1) && (int'(min_pos) == MINS - 1);
        in_span = (sec_pos == '0) && (int'(min_pos) < 2 * int'(cal_q[MAG_W-1:0]));
    end

    a_r2_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> osc_en);
    a_r3_sec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sec_pos) < SECS);
    a_r3_pos_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(sec_pos) && $stable(min_pos));
    a_r1_plain_length: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !in_span) |-> (en_cnt == BASE_CYCLES - 1));
    a_r4_short_length: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && in_span && cal_q[MAG_W]) |-> (en_cnt == BASE_CYCLES - SHORT_BY - 1));
    a_r5_long_length: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && in_span && !cal_q[MAG_W]) |-> (en_cnt == BASE_CYCLES + LONG_BY - 1));
    a_r6_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && cal_q[MAG_W-1:0] == '0) |-> (en_cnt == BASE_CYCLES - 1));
    a_r8_cal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !at_wrap |=> $stable(cal_q));
    a_r9_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (sec_pos == '0) && (min_pos == '0));
endmodule

bind rate_trim_prescaler rtp_checker #(
    .BASE_CYCLES(BASE_CYCLES), .SHORT_BY(SHORT_BY), .LONG_BY(LONG_BY),
    .SECS(SECS), .MINS(MINS), .MAG_W(MAG_W), .SEC_W(SEC_W), .MIN_W(MIN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sec_tick(sec_tick),
    .sec_pos(sec_pos), .min_pos(min_pos), .cal_q(cal_q)
);

// File: tb/sim_rate_trim_prescaler.sv
`timescale 1ns/100ps
module sim_rate_trim_prescaler;
    localparam int BASE  = 64;
    localparam int SHORT = 32;
    localparam int LONG  = 16;
    localparam int SECS  = 3;
    localparam int MINS  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       hush = 1'b0;
    logic [5:0] cal_in = 6'h25;
    logic       sec_tick;
    logic [1:0] sec_pos;
    logic [5:0] min_pos;

    int n_run = 0;
    int n_fail = 0;
    int m_sec = 0;
    int m_min = 0;
    int m_cnt = 0;
    logic [5:0] m_cal = 6'h25;

    always #2.5 clk = ~clk;

    rate_trim_prescaler #(
        .BASE_CYCLES(BASE), .SHORT_BY(SHORT), .LONG_BY(LONG),
        .SECS(SECS), .MINS(MINS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_in(cal_in),
        .sec_tick(sec_tick), .sec_pos(sec_pos), .min_pos(min_pos)
    );

    function automatic int exp_len(int mn, int sc, logic [5:0] cal);
        if (sc == 0 && mn < 2 * int'(cal[4:0]))
            return cal[5] ? BASE - SHORT : BASE + LONG;
        return BASE;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // reference model, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_cnt = 0; m_cal = cal_in;
        end else begin
            if (osc_en) m_cnt++;
            if (sec_tick) begin
                check(osc_en, "R2 tick without enable", int'(osc_en), 1);
                // R1 R4 R5 R6 R7 R10: length in enabled cycles
                check(m_cnt == exp_len(m_min, m_sec, m_cal), "R1/R4/R5/R6/R7 length",
                      m_cnt, exp_len(m_min, m_sec, m_cal));
                check(int'(sec_pos) == m_sec && int'(min_pos) == m_min, "R3 position",
                      int'(min_pos) * 100 + int'(sec_pos), m_min * 100 + m_sec);
                m_cnt = 0;
                if (m_sec == SECS - 1) begin
                    m_sec = 0;
                    if (m_min == MINS - 1) begin
                        m_min = 0;
                        m_cal = cal_in; // R8 sampling point
                    end else m_min++;
                end else m_sec++;
            end
        end
    end

    // oscillator enable, gaps at random
    initial begin
        forever begin
            @(posedge clk); #1;
            osc_en = !hush && (($urandom % 8) != 0);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    logic [5:0] plan [7];

    initial begin
        void'($urandom(32'd20240611));
        plan[0] = 6'h3F; plan[1] = 6'h1F; plan[2] = 6'h20; plan[3] = 6'h00;
        plan[4] = 6'h21; plan[5] = 6'h06; plan[6] = 6'($urandom);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sec_pos == 0 && min_pos == 0 && !sec_tick, "R9 reset state",
              int'(sec_pos) + int'(min_pos), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        // R10: a stretch with no enable must not move the position
        @(posedge clk); #1; hush = 1'b1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(sec_pos == 0 && min_pos == 0, "R10 no advance without enable",
              int'(sec_pos) + int'(min_pos), 0);
        @(posedge clk); #1; hush = 1'b0;
        for (int k = 0; k < 7; k++) begin
            wait (m_min == 20);
            @(posedge clk); #1; cal_in = 6'($urandom); // R8: mid-cycle change is ignored
            wait (m_min == MINS - 1);
            @(posedge clk); #1; cal_in = plan[k];
            wait (m_min == 0);
        end
        // R9: reset in mid-run, the word held in reset governs the new cycle
        wait (m_min == 5);
        @(posedge clk); #1; rst_n = 1'b0; cal_in = 6'h02;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sec_pos == 0 && min_pos == 0, "R9 mid-run reset",
              int'(sec_pos) + int'(min_pos), 0);
        @(posedge clk); #1; rst_n = 1'b1; cal_in = 6'h3F;
        wait (m_min == 6);
        @(posedge clk);
        summary();
    end
endmodule